// File: doc/BRIEF.md
# Product-Term Cluster Steering Allocator

This block is the routing stage between the product-term clusters of one logic block and its sixteen macrocells. Each macrocell slot has one cluster. A cluster gives a single sum bit, which is the OR of its product terms. A per-cluster steering code decides where that sum goes. It can go to the cluster's own macrocell. It can go one hop along its expansion chain. It can also be dropped.

The sixteen slots form four interleaved chains with a stride of four: slot n feeds slot n+4. The top four slots wrap back onto the bottom four. A macrocell output is the OR of its own cluster, when that cluster is kept local, and of the cluster steered in from the slot four below it. This lets a wide function collect the terms of two clusters. A destination that no cluster selects is held at logic 0. That covers the source slot of a steered cluster, unless something else lands on it.

The steering codes sit in a 32-bit configuration register. It is written whole through a strobed write port and resets to all-local. The data path from cluster sums to macrocell sums is purely combinational.

Top module: `pt_steer_alloc`

## Requirements
- R1: After reset every cluster code is local (00), so each macrocell output equals its own cluster input.
- R2: Code 00 in field `cfg_wdata[2n+1:2n]` keeps cluster n on macrocell output n.
- R3: Code 01 for cluster n drives its value onto output (n+4) mod 16, and that cluster contributes nothing to output n.
- R4: Steering from slots 12 to 15 wraps onto outputs 0 to 3 respectively.
- R5: Code 10 disables cluster n, so it contributes 0 to every output.
- R6: Code 11 is reserved and behaves exactly like code 10.
- R7: An output is the OR of its own local cluster and the cluster steered into it from slot n-4 (mod 16).
- R8: Steering takes one hop only. A cluster steered into slot n, where cluster n is itself steered, appears on output n and not on output n+4.
- R9: A write with `cfg_we` high takes effect in the cycle after the clock edge that captures it. When `cfg_we` is low, the configuration does not change, whatever is on `cfg_wdata`.
- R10: Steering never crosses chains: output m depends only on clusters m and (m-4) mod 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration register |
| rst_n | input | 1 | Synchronous active-low reset, loads all-local codes |
| cfg_we | input | 1 | Write strobe for the configuration register |
| cfg_wdata | input | 32 | New steering codes, two bits per cluster, cluster n at bits 2n+1:2n |
| clus_sum | input | 16 | Cluster sum bits, bit n for slot n |
| mc_sum | output | 16 | Combined sum outputs to the macrocells, bit n for macrocell n |

## Verification
Two things can meet on one output in the same evaluation. One is the local contribution of a slot. The other is the value steered into that slot from four below. On top of that, the slot's own cluster may be leaving for the next hop while a value arrives. The bench provokes these cases by steering slot 0 with slot 4 held local, and by steering both slots 0 and 4. It then drives one-hot and combined cluster patterns. It judges the result against an independent per-output OR model. That model must show an OR, a grounded source and no second hop.

// File: rtl/pt_steer_pkg.sv
// Package: pt_steer_pkg
// Purpose : shared steering-code encoding for the cluster allocator.
// Assumes : two-bit codes; the upper bit set means the cluster is dropped.
package pt_steer_pkg;
    typedef enum logic [1:0] {
        STEER_LOCAL = 2'b00,
        STEER_NEXT  = 2'b01,
        STEER_OFF   = 2'b10,
        STEER_RSVD  = 2'b11
    } steer_code_e;

    localparam int STEER_CODE_W = 2;
endpackage

// File: rtl/pt_cfg_bank.sv
// Module : pt_cfg_bank
// Purpose: holds the steering codes of all clusters; whole-word write.
// Assumes: synchronous active-low reset to all-local (zero) codes; the
//          written word is visible on cfg_q in the cycle after the edge.
module pt_cfg_bank #(
    parameter int NUM_SLOTS = 16,
    parameter int CODE_W    = 2,
    localparam int CFG_W    = NUM_SLOTS * CODE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output logic [CFG_W-1:0] cfg_q
);

    // Capture a new configuration word on a strobed write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (we) begin
            cfg_q <= wdata;
        end
    end

    // R9
    cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (cfg_q == $past(wdata)));

    // R9
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(cfg_q));

endmodule

// File: rtl/pt_slot_decode.sv
// Module : pt_slot_decode
// Purpose: splits one cluster sum into a local part and a forwarded part.
// Assumes: the reserved code acts as disabled; at most one part is live.
module pt_slot_decode
    import pt_steer_pkg::*;
#(
    parameter int CODE_W = STEER_CODE_W
) (
    input  logic [CODE_W-1:0] code,
    input  logic              sum_in,
    output logic              keep,
    output logic              fwd
);

    steer_code_e code_e;

    // Decode the steering code into local and forward enables.
    always_comb begin
        code_e = steer_code_e'(code[1:0]);
        keep   = 1'b0;
        fwd    = 1'b0;
        case (code_e)
            STEER_LOCAL: keep = sum_in;
            STEER_NEXT:  fwd  = sum_in;
            default: begin
                keep = 1'b0;
                fwd  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/pt_chain_merge.sv
// Module : pt_chain_merge
// Purpose: merges local parts with the parts forwarded one stride down
//          each expansion chain; wraps from the top slots to the bottom.
// Assumes: one hop only; a forwarded part is never forwarded again.
module pt_chain_merge #(
    parameter int NUM_SLOTS = 16,
    parameter int STRIDE    = 4
) (
    input  logic [NUM_SLOTS-1:0] keep,
    input  logic [NUM_SLOTS-1:0] fwd,
    output logic [NUM_SLOTS-1:0] merged
);

    for (genvar m = 0; m < NUM_SLOTS; m++) begin : g_dst
        localparam int SRC = (m + NUM_SLOTS - STRIDE) % NUM_SLOTS;
        // OR the slot's own part with the part arriving from SRC.
        always_comb begin
            merged[m] = keep[m] | fwd[SRC];
        end
    end

endmodule

// File: rtl/pt_steer_alloc.sv
// Module : pt_steer_alloc
// Purpose: top of the cluster steering allocator; configuration register,
//          per-slot decode and chain merge.
// Assumes: cluster n's code sits at cfg_wdata[2n+1:2n]; outputs follow
//          cluster inputs combinationally.
module pt_steer_alloc
    import pt_steer_pkg::*;
#(
    parameter int NUM_SLOTS = 16,
    parameter int STRIDE    = 4,
    localparam int CODE_W   = STEER_CODE_W,
    localparam int CFG_W    = NUM_SLOTS * CODE_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [CFG_W-1:0]     cfg_wdata,
    input  logic [NUM_SLOTS-1:0] clus_sum,
    output logic [NUM_SLOTS-1:0] mc_sum
);

    logic [CFG_W-1:0]     cfg_q;
    logic [NUM_SLOTS-1:0] keep;
    logic [NUM_SLOTS-1:0] fwd;

    pt_cfg_bank #(
        .NUM_SLOTS (NUM_SLOTS),
        .CODE_W    (CODE_W)
    ) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg_q (cfg_q)
    );

    for (genvar n = 0; n < NUM_SLOTS; n++) begin : g_slot
        pt_slot_decode #(
            .CODE_W (CODE_W)
        ) u_dec (
            .code   (cfg_q[n*CODE_W +: CODE_W]),
            .sum_in (clus_sum[n]),
            .keep   (keep[n]),
            .fwd    (fwd[n])
        );
    end

    pt_chain_merge #(
        .NUM_SLOTS (NUM_SLOTS),
        .STRIDE    (STRIDE)
    ) u_merge (
        .keep   (keep),
        .fwd    (fwd),
        .merged (mc_sum)
    );

    for (genvar m = 0; m < NUM_SLOTS; m++) begin : g_chk
        localparam int SRC = (m + NUM_SLOTS - STRIDE) % NUM_SLOTS;
        localparam int DST = (m + STRIDE) % NUM_SLOTS;
        logic [CODE_W-1:0] code_m;
        logic [CODE_W-1:0] code_src;
        // Pick out the codes of this slot and of its chain predecessor.
        always_comb begin
            code_m   = cfg_q[m*CODE_W +: CODE_W];
            code_src = cfg_q[SRC*CODE_W +: CODE_W];
        end

        // R2
        local_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (code_m == STEER_LOCAL && clus_sum[m]) |-> mc_sum[m]);

        // R3
        steer_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (code_m == STEER_NEXT && clus_sum[m]) |-> mc_sum[DST]);

        // R3
        steer_ground_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (code_m == STEER_NEXT && !(code_src == STEER_NEXT && clus_sum[SRC]))
            |-> !mc_sum[m]);

        // R5
        disabled_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (code_m == STEER_OFF && !(code_src == STEER_NEXT && clus_sum[SRC]))
            |-> !mc_sum[m]);

        // R6
        reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (code_m == STEER_RSVD && !(code_src == STEER_NEXT && clus_sum[SRC]))
            |-> !mc_sum[m]);

        // R10
        chain_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!clus_sum[m] && !clus_sum[SRC]) |-> !mc_sum[m]);
    end

endmodule

// File: tb/pt_steer_alloc_tb.sv
`timescale 1ns/1ps
module pt_steer_alloc_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [15:0] clus_sum = '0;
    logic [15:0] mc_sum;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    pt_steer_alloc u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .clus_sum  (clus_sum),
        .mc_sum    (mc_sum)
    );

    // Reference: output m = local cluster m OR cluster m-4 steered in.
    function automatic logic [15:0] model(input logic [31:0] c, input logic [15:0] s);
        logic [15:0] r;
        for (int m = 0; m < 16; m++) begin
            int src;
            src  = (m + 12) % 16;
            r[m] = ((c[2*m +: 2] == 2'b00) && s[m]) ||
                   ((c[2*src +: 2] == 2'b01) && s[src]);
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [31:0] v);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic apply(input string tag, input logic [15:0] s, input logic [15:0] exp);
        clus_sum = s;
        #1;
        check(tag, mc_sum, exp);
    endtask

    task automatic t_reset();
        apply("R1 reset all-local", 16'h5A3C, 16'h5A3C);
        apply("R1 reset all-ones", 16'hFFFF, 16'hFFFF);
    endtask

    task automatic t_local();
        write_cfg(32'h0);
        apply("R2 local pattern", 16'hA5C3, 16'hA5C3);
        apply("R2 local zero", 16'h0000, 16'h0000);
    endtask

    task automatic t_steer();
        write_cfg(32'h0000_0400);
        apply("R3 steer 5 to 9", 16'h0020, 16'h0200);
        apply("R3 source grounded", 16'hFFFF, 16'hFFDF);
    endtask

    task automatic t_wrap();
        write_cfg(32'h5500_0000);
        apply("R4 wrap top to bottom", 16'hF000, 16'h000F);
        apply("R4 wrap with local bottom", 16'hF00F, 16'h000F);
        apply("R4 wrap slot 13 to 1", 16'h2000, 16'h0002);
    endtask

    task automatic t_disable();
        write_cfg(32'hAAAA_AAAA);
        apply("R5 all disabled", 16'hFFFF, 16'h0000);
        write_cfg(32'h0000_0020);
        apply("R5 slot 2 disabled", 16'hFFFF, 16'hFFFB);
    endtask

    task automatic t_reserved();
        write_cfg(32'hFFFF_FFFF);
        apply("R6 all reserved", 16'hFFFF, 16'h0000);
        write_cfg(32'h0000_00C0);
        apply("R6 slot 3 reserved", 16'h0008, 16'h0000);
        apply("R6 slot 3 reserved others", 16'hFFFF, 16'hFFF7);
    endtask

    task automatic t_accum();
        write_cfg(32'h0000_0001);
        apply("R7 steered only", 16'h0001, 16'h0010);
        apply("R7 local only", 16'h0010, 16'h0010);
        apply("R7 both merged", 16'h0011, 16'h0010);
    endtask

    task automatic t_nontrans();
        write_cfg(32'h0000_0101);
        apply("R8 one hop from 0", 16'h0001, 16'h0010);
        apply("R8 one hop from 4", 16'h0010, 16'h0100);
        apply("R8 both steered", 16'h0011, 16'h0110);
    endtask

    task automatic t_timing();
        write_cfg(32'h0);
        clus_sum = 16'h0001;
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = 32'h0000_0001;
        #2;
        check("R9 old config before edge", mc_sum, 16'h0001);
        @(negedge clk);
        cfg_we = 1'b0;
        #1;
        check("R9 new config after edge", mc_sum, 16'h0010);
        cfg_wdata = 32'hAAAA_AAAA;
        @(negedge clk);
        @(negedge clk);
        #1;
        check("R9 no write when strobe low", mc_sum, 16'h0010);
    endtask

    task automatic t_chain_iso();
        logic [31:0] c;
        logic [15:0] s;
        write_cfg(32'h5555_5555);
        apply("R10 all steered one-hot", 16'h0001, 16'h0010);
        apply("R10 all steered full", 16'hFFFF, 16'hFFFF);
        c = 32'h1D2B_39C7;
        s = 16'hACE1;
        for (int i = 0; i < 20; i++) begin
            c = {c[30:0], c[31] ^ c[21] ^ c[1] ^ c[0]};
            s = {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
            write_cfg(c);
            apply("R10 mixed pattern", s, model(c, s));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_local();
        t_steer();
        t_wrap();
        t_disable();
        t_reserved();
        t_accum();
        t_nontrans();
        t_timing();
        t_chain_iso();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule